// File: doc/BRIEF.md
# Shared I2C Pin Multiplexer for a Write Engine and a Read Engine

This block lets two separate I2C master engines use a single SCL/SDA pin pair. One engine writes configuration registers, the other reads them back. Each engine offers its SCL level, an SDA output value, an SDA drive enable and an idle flag. The multiplexer drives the pins from whichever engine currently holds the grant. It sends each engine an enable, and it returns one synchronised copy of the SDA pin to both engines as their receive input.

The pins are open-drain in style. SCL is output as a level, and SDA is output as a pull-low request that the pad turns into drive-low or release. After reset the write engine holds the grant. The read engine is enabled only after two things have happened: the write engine has signalled completion with a one-cycle done pulse, and it has then gone idle. Between the two owners the bus rests for a fixed number of cycles with no owner.

Top module: `i2c_share_mux`

## Requirements
- R1: After reset the write engine holds the grant (`wr_en_o`=1, `rd_en_o`=0), `sda_rx_o` is 1, and with an idle write engine `scl_pin_o`=1 and `sda_pull_low_o`=0.
- R2: While the write engine holds the grant and is not idle, `scl_pin_o` equals `wr_scl_i`. None of the read engine's inputs affects either pin output.
- R3: `sda_pull_low_o` is 1 only when the granted engine is not idle, its drive enable is 1 and its SDA output value is 0. In every other case SDA is released (0), whatever the output value is.
- R4: When the granted engine reports idle, `scl_pin_o` is 1 and `sda_pull_low_o` is 0, whatever that engine's SCL and SDA inputs are.
- R5: A one-cycle `wr_done_i` pulse sets a write-complete flag that stays set until reset. `rd_en_o` stays 0 as long as the flag is clear.
- R6: The grant leaves the write engine only when the flag is set and `wr_idle_i` is 1. A busy write engine keeps the grant for as long as it stays busy.
- R7: The handover from write to read has HANDOVER_GAP cycles in which neither enable is 1 (default 4). Counted from the first clock edge at which the flag is set and the write engine is idle, the grant leaves the write engine at that edge and `rd_en_o` rises HANDOVER_GAP edges later. During the gap `scl_pin_o`=1 and `sda_pull_low_o`=0, whatever the inputs are.
- R8: Once granted, the read engine keeps the grant until reset. Its inputs drive the pins under the rules of R3 and R4, the write engine's inputs have no effect, and further `wr_done_i` pulses change nothing.
- R9: `sda_rx_o` equals the value of `sda_pin_i` from two clock edges earlier (a two-stage synchroniser).
- R10: A reset given after the handover returns the grant to the write engine and clears the write-complete flag. With no new done pulse, `rd_en_o` then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_scl_i | input | 1 | SCL level requested by the write engine |
| wr_sda_out_i | input | 1 | SDA value from the write engine |
| wr_sda_oe_i | input | 1 | Write engine SDA drive enable (1 = drive) |
| wr_idle_i | input | 1 | Write engine is idle |
| wr_done_i | input | 1 | One-cycle pulse: configuration writes finished |
| rd_scl_i | input | 1 | SCL level requested by the read engine |
| rd_sda_out_i | input | 1 | SDA value from the read engine |
| rd_sda_oe_i | input | 1 | Read engine SDA drive enable (1 = drive) |
| rd_idle_i | input | 1 | Read engine is idle |
| sda_pin_i | input | 1 | Level seen on the shared SDA pin |
| scl_pin_o | output | 1 | Level for the shared SCL pin |
| sda_pull_low_o | output | 1 | 1 = pull shared SDA low, 0 = release |
| sda_rx_o | output | 1 | Synchronised SDA, sent to both engines |
| wr_en_o | output | 1 | Enable for the write engine (grant held) |
| rd_en_o | output | 1 | Enable for the read engine (grant held) |

## Verification
Two functions can act in the same cycle. The first is the grant change: the done pulse can arrive in the cycle the write engine goes idle, or while it is still busy. The second is the pin drive, which switches owner in that same cycle. The bench holds the write engine busy across the done pulse and checks that the grant stays put. It then releases idle and checks the exact edge at which both enables drop, the length of the gap with the pins forced released, and the cycle in which the read enable rises. Exhaustive sweeps of all eight engine inputs, run under each grant, check that the pin outputs follow only the owner.

// File: rtl/i2c_share_mux_pkg.sv
package i2c_share_mux_pkg;

    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_WR   = 2'd1,
        GNT_RD   = 2'd2
    } grant_e;

    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned SRC_WR  = 0;
    localparam int unsigned SRC_RD  = 1;

    typedef struct packed {
        logic scl;
        logic sda_out;
        logic sda_oe;
        logic idle;
    } eng_drive_t;

    typedef struct packed {
        logic scl;
        logic pull_low;
    } pin_drive_t;

    localparam pin_drive_t PIN_RELEASED = '{scl: 1'b1, pull_low: 1'b0};

    // Open-drain resolution of one engine's request.
    function automatic pin_drive_t resolve_drive(eng_drive_t e);
        pin_drive_t p;
        if (e.idle) begin
            p = PIN_RELEASED;
        end else begin
            p.scl      = e.scl;
            p.pull_low = e.sda_oe & ~e.sda_out;
        end
        return p;
    endfunction

endpackage

// File: rtl/bmx_sync.sv
module bmx_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RESET_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bmx_arbiter.sv
module bmx_arbiter
    import i2c_share_mux_pkg::*;
#(
    parameter int unsigned HANDOVER_GAP = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_done_i,
    input  logic   wr_idle_i,
    output grant_e grant_o
);
    localparam int unsigned CW = (HANDOVER_GAP > 1) ? $clog2(HANDOVER_GAP) : 1;
    localparam logic [CW-1:0] GAP_LAST = CW'(HANDOVER_GAP - 1);

    grant_e        grant_q, grant_d;
    logic          complete_q;
    logic [CW-1:0] gap_q, gap_d;

    // Sticky completion flag.
    always_ff @(posedge clk) begin
        if (rst)            complete_q <= 1'b0;
        else if (wr_done_i) complete_q <= 1'b1;
    end

    always_comb begin
        grant_d = grant_q;
        gap_d   = gap_q;
        unique case (grant_q)
            GNT_WR: begin
                if (complete_q && wr_idle_i) begin
                    grant_d = GNT_NONE;
                    gap_d   = '0;
                end
            end
            GNT_NONE: begin
                if (gap_q == GAP_LAST) grant_d = GNT_RD;
                else                   gap_d   = gap_q + 1'b1;
            end
            GNT_RD:  grant_d = GNT_RD;
            default: grant_d = GNT_WR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= GNT_WR;
            gap_q   <= '0;
        end else begin
            grant_q <= grant_d;
            gap_q   <= gap_d;
        end
    end

    assign grant_o = grant_q;
endmodule

// File: rtl/bmx_pin_drive.sv
module bmx_pin_drive
    import i2c_share_mux_pkg::*;
(
    input  grant_e     grant_i,
    input  eng_drive_t src_i [NUM_SRC],
    output pin_drive_t pin_o,
    output logic       wr_en_o,
    output logic       rd_en_o
);
    pin_drive_t resolved [NUM_SRC];

    genvar k;
    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_src
            assign resolved[k] = resolve_drive(src_i[k]);
        end
    endgenerate

    always_comb begin
        unique case (grant_i)
            GNT_WR:  pin_o = resolved[SRC_WR];
            GNT_RD:  pin_o = resolved[SRC_RD];
            default: pin_o = PIN_RELEASED;
        endcase
    end

    assign wr_en_o = (grant_i == GNT_WR);
    assign rd_en_o = (grant_i == GNT_RD);
endmodule

// File: rtl/i2c_share_mux.sv
module i2c_share_mux
    import i2c_share_mux_pkg::*;
#(
    parameter int unsigned HANDOVER_GAP = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_scl_i,
    input  logic wr_sda_out_i,
    input  logic wr_sda_oe_i,
    input  logic wr_idle_i,
    input  logic wr_done_i,
    input  logic rd_scl_i,
    input  logic rd_sda_out_i,
    input  logic rd_sda_oe_i,
    input  logic rd_idle_i,
    input  logic sda_pin_i,
    output logic scl_pin_o,
    output logic sda_pull_low_o,
    output logic sda_rx_o,
    output logic wr_en_o,
    output logic rd_en_o
);
    grant_e     grant;
    eng_drive_t src [NUM_SRC];
    pin_drive_t pin;

    assign src[SRC_WR] = '{scl: wr_scl_i, sda_out: wr_sda_out_i,
                           sda_oe: wr_sda_oe_i, idle: wr_idle_i};
    assign src[SRC_RD] = '{scl: rd_scl_i, sda_out: rd_sda_out_i,
                           sda_oe: rd_sda_oe_i, idle: rd_idle_i};

    bmx_arbiter #(.HANDOVER_GAP(HANDOVER_GAP)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .wr_done_i (wr_done_i),
        .wr_idle_i (wr_idle_i),
        .grant_o   (grant)
    );

    bmx_pin_drive u_drive (
        .grant_i (grant),
        .src_i   (src),
        .pin_o   (pin),
        .wr_en_o (wr_en_o),
        .rd_en_o (rd_en_o)
    );

    bmx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sda_pin_i),
        .q_o (sda_rx_o)
    );

    assign scl_pin_o      = pin.scl;
    assign sda_pull_low_o = pin.pull_low;
endmodule

// File: rtl/i2c_share_mux_chk.sv
module i2c_share_mux_chk #(
    parameter int unsigned HANDOVER_GAP = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input logic clk,
    input logic rst,
    input logic wr_scl_i,
    input logic wr_sda_out_i,
    input logic wr_sda_oe_i,
    input logic wr_idle_i,
    input logic wr_done_i,
    input logic rd_sda_out_i,
    input logic rd_sda_oe_i,
    input logic rd_idle_i,
    input logic sda_pin_i,
    input logic scl_pin_o,
    input logic sda_pull_low_o,
    input logic sda_rx_o,
    input logic wr_en_o,
    input logic rd_en_o
);
    logic        seen_done;
    logic [1:0]  since_rst;
    logic [31:0] idle_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_done <= 1'b0;
            since_rst <= '0;
            idle_gap  <= '0;
        end else begin
            if (wr_done_i) seen_done <= 1'b1;
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            if (!wr_en_o && !rd_en_o) idle_gap <= idle_gap + 32'd1;
            else                      idle_gap <= '0;
        end
    end

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en_o, rd_en_o})); // R8

    AST_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> seen_done); // R5

    AST_WR_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !wr_idle_i) |=> wr_en_o); // R6

    AST_RD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |=> rd_en_o); // R8

    AST_WR_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && wr_idle_i) |-> (scl_pin_o && !sda_pull_low_o)); // R4

    AST_PULL_NEEDS_OWNER: assert property (@(posedge clk) disable iff (rst)
        sda_pull_low_o |-> ((wr_en_o && wr_sda_oe_i && !wr_sda_out_i && !wr_idle_i) ||
                            (rd_en_o && rd_sda_oe_i && !rd_sda_out_i && !rd_idle_i))); // R3

    AST_WR_SCL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && !wr_idle_i) |-> (scl_pin_o == wr_scl_i)); // R2

    AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en_o) |-> (idle_gap == 32'(HANDOVER_GAP))); // R7

    generate
        if (SYNC_STAGES == 2) begin : g_sync_chk
            AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
                (since_rst == 2'd3) |-> (sda_rx_o == $past(sda_pin_i, 2))); // R9
        end
    endgenerate
endmodule

bind i2c_share_mux i2c_share_mux_chk #(
    .HANDOVER_GAP (HANDOVER_GAP),
    .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_scl_i       (wr_scl_i),
    .wr_sda_out_i   (wr_sda_out_i),
    .wr_sda_oe_i    (wr_sda_oe_i),
    .wr_idle_i      (wr_idle_i),
    .wr_done_i      (wr_done_i),
    .rd_sda_out_i   (rd_sda_out_i),
    .rd_sda_oe_i    (rd_sda_oe_i),
    .rd_idle_i      (rd_idle_i),
    .sda_pin_i      (sda_pin_i),
    .scl_pin_o      (scl_pin_o),
    .sda_pull_low_o (sda_pull_low_o),
    .sda_rx_o       (sda_rx_o),
    .wr_en_o        (wr_en_o),
    .rd_en_o        (rd_en_o)
);

// File: tb/sim_i2c_share_mux.sv
`timescale 1ns / 1ps
module sim_i2c_share_mux;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_scl = 1'b1, wr_out = 1'b1, wr_oe = 1'b0, wr_idle = 1'b1, wr_done = 1'b0;
    logic rd_scl = 1'b1, rd_out = 1'b1, rd_oe = 1'b0, rd_idle = 1'b1;
    logic sda_pin = 1'b1;
    logic scl_pin, pull_low, sda_rx, wr_en, rd_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    i2c_share_mux #(.HANDOVER_GAP(GAP), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst),
        .wr_scl_i(wr_scl), .wr_sda_out_i(wr_out), .wr_sda_oe_i(wr_oe),
        .wr_idle_i(wr_idle), .wr_done_i(wr_done),
        .rd_scl_i(rd_scl), .rd_sda_out_i(rd_out), .rd_sda_oe_i(rd_oe),
        .rd_idle_i(rd_idle), .sda_pin_i(sda_pin),
        .scl_pin_o(scl_pin), .sda_pull_low_o(pull_low), .sda_rx_o(sda_rx),
        .wr_en_o(wr_en), .rd_en_o(rd_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {scl, pull_low, wr_en, rd_en} for a given owner: 0 none, 1 write, 2 read.
    function automatic logic [3:0] expect_pins(input int owner, input logic [3:0] w, input logic [3:0] r);
        logic [3:0] e;
        logic s, p;
        e = (owner == 1) ? w : r;  // bits: 3 scl, 2 out, 1 oe, 0 idle
        if (owner == 0 || e[0]) begin
            s = 1'b1; p = 1'b0;
        end else begin
            s = e[3]; p = e[1] & ~e[2];
        end
        return {s, p, owner == 1, owner == 2};
    endfunction

    task automatic sweep(input int owner, input string req);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            {wr_scl, wr_out, wr_oe, wr_idle} = v[3:0];
            {rd_scl, rd_out, rd_oe, rd_idle} = v[7:4];
            #2;
            check(req, {4'b0, scl_pin, pull_low, wr_en, rd_en},
                  {4'b0, expect_pins(owner, v[3:0], v[7:4])});
        end
    endtask

    initial begin
        logic hist [0:39];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        check("R1", {4'b0, scl_pin, pull_low, wr_en, rd_en}, 8'b0000_1010);
        check("R1", {7'b0, sda_rx}, 8'h01);

        // R2 R3 R4: write owner, every input pattern
        sweep(1, "R2/R3/R4 write owner");

        // R5 R6: idle write engine, no done pulse: grant stays
        @(negedge clk);
        {wr_scl, wr_out, wr_oe, wr_idle} = 4'b1001;
        repeat (10) @(negedge clk);
        #2;
        check("R5 no read before done", {6'b0, wr_en, rd_en}, 8'h02);

        // R6: done pulse while busy, grant held
        wr_idle = 1'b0;
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #2;
            check("R6 busy keeps grant", {6'b0, wr_en, rd_en}, 8'h02);
        end

        // R7: release idle; engines request pull-low during the gap
        wr_idle = 1'b1;
        {rd_scl, rd_out, rd_oe, rd_idle} = 4'b0010;
        for (int i = 0; i < GAP; i++) begin
            @(negedge clk);
            #2;
            check("R7 gap released", {4'b0, scl_pin, pull_low, wr_en, rd_en}, 8'b0000_1000);
            wr_idle = 1'b0; wr_scl = 1'b0; wr_oe = 1'b1; wr_out = 1'b0;
        end
        @(negedge clk);
        #2;
        check("R7 read granted after gap", {4'b0, scl_pin, pull_low, wr_en, rd_en}, 8'b0000_0101);

        // R8: read owner, every input pattern
        sweep(2, "R8/R3/R4 read owner");

        // R8: more done pulses do nothing
        @(negedge clk);
        wr_done = 1'b1; wr_idle = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check("R8 read keeps grant", {6'b0, wr_en, rd_en}, 8'h01);

        // R9: synchroniser latency
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #2;
            if (i >= 2) check("R9 sync delay", {7'b0, sda_rx}, {7'b0, hist[i-2]});
            hist[i] = ((i * 7 + i / 3) % 5) < 2;
            sda_pin = hist[i];
        end

        // R10: reset returns grant to write, flag cleared
        @(negedge clk);
        rst = 1'b1; sda_pin = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        wr_idle = 1'b1;
        #2;
        check("R10 grant back to write", {6'b0, wr_en, rd_en}, 8'h02);
        check("R1 sync reset value", {7'b0, sda_rx}, 8'h01);
        repeat (12) @(negedge clk);
        #2;
        check("R10 flag cleared", {6'b0, wr_en, rd_en}, 8'h02);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule